// File: doc/BRIEF.md
# Gated Event Counter Bank

This block counts logic pulses arriving on ten independent event inputs. Each channel owns a 16-bit down-counter that starts from all ones and loses one count for every rising edge seen on its input, but only while a shared enable is high. That enable comes from an acquisition timer, so every channel opens and closes at the same moment. When the run is over, software reads each channel and works out its event total as 16'hFFFF minus the reading.

The event inputs are asynchronous. Each one passes through a two-flop synchroniser and an edge detector, so a pulse that lasts many clock cycles counts only once. A single write strobe presets every counter to all ones and clears the per-channel overflow flags. A 4-bit channel select drives a combinational 16-bit read port. If a counter reaches zero it stays there and raises a sticky overflow flag for its channel; it never wraps.

Top module: `evc_counter_bank`

## Requirements
- R1: After reset every channel reads 16'hFFFF and every overflow flag is 0.
- R2: When `preset_wr` is high at a rising clock edge, every counter becomes 16'hFFFF and every overflow flag becomes 0. This wins over an event counted at the same edge.
- R3: Each rising edge on a channel input, counted while `gate_en` is high, lowers that channel's counter by exactly one. An input held high for many cycles counts once.
- R4: While `gate_en` is low, no counter changes. An input edge that reaches the counter at a clock edge where `gate_en` is already low is lost; it is not counted later.
- R5: A counter at zero stays at zero when a further event is counted. It sets its `ovf_flags` bit, and that bit stays high until a preset or a reset.
- R6: `rd_data` shows the counter selected by `rd_sel` in the same cycle, with channel k at select value k for k from 0 to 9. Select values 10 to 15 read as 0.
- R7: An input that rises just after clock edge 0 changes the counter at clock edge 3. That is two synchroniser stages plus one edge register.
- R8: Channels are independent. Edges on several inputs in the same cycle each count on their own channel and leave the other channels unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_in | input | 10 | Asynchronous event inputs, one per channel |
| gate_en | input | 1 | Shared count enable from the acquisition timer, active high |
| preset_wr | input | 1 | Strobe that loads all counters with all ones and clears the flags |
| rd_sel | input | 4 | Channel select for the read port |
| rd_data | output | 16 | Present value of the selected counter |
| ovf_flags | output | 10 | Sticky per-channel flags that show a counter hit zero and saw more events |

## Verification
An event input the bench raises just after a falling edge is counted at the third rising edge that follows. The bench therefore waits three clocks, or lets each pulse take its four-cycle slot, before it reads a counter. A preset takes effect at the first rising edge. The read port is combinational, so it is checked 1 ns after the select changes on a falling edge. For the gate-fall and preset-priority cases, the gate or the strobe is placed exactly on the third edge, so the bench tests the edge where the counter would otherwise move.

// File: rtl/evc_pkg.sv
// Shared sizing for the gated event counter bank.
// Assumes: all instances of the bank use these values unless overridden.
package evc_pkg;
    parameter int EVC_NCH = 10;   // number of counting channels
    parameter int EVC_CW  = 16;   // width of each channel counter
endpackage

// File: rtl/evc_edge_sync.sv
// Synchronises a vector of asynchronous event inputs and produces a
// one-cycle rise pulse per bit.
// Assumes: each input stays high for at least one clock period.
module evc_edge_sync #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] rise
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [W-1:0] prev_q;

    // two-flop synchroniser followed by a history register for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= din;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // a bit rises when the synchronised value is 1 and was 0 a cycle before
    assign rise = sync_q & ~prev_q;
endmodule

// File: rtl/evc_chan_counter.sv
// One saturating down-counter channel with preset and a sticky overflow flag.
// Assumes: step is already qualified by the shared gate.
module evc_chan_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          preset,
    input  logic          step,
    output logic [CW-1:0] count,
    output logic          ovf
);
    localparam logic [CW-1:0] ALL_ONES = '1;

    // preset wins over a step; at zero the count holds and the flag is set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= ALL_ONES;
            ovf   <= 1'b0;
        end else if (preset) begin
            count <= ALL_ONES;
            ovf   <= 1'b0;
        end else if (step) begin
            if (count == '0) begin
                ovf <= 1'b1;
            end else begin
                count <= count - 1'b1;
            end
        end
    end
endmodule

// File: rtl/evc_read_mux.sv
// Combinational channel select for the read port.
// Assumes: select values at or above the channel count read as zero.
module evc_read_mux #(
    parameter int NCH  = 10,
    parameter int CW   = 16,
    parameter int SELW = 4
) (
    input  logic [NCH*CW-1:0] cnt_bus,
    input  logic [SELW-1:0]   sel,
    output logic [CW-1:0]     data
);
    // pick the slice whose index matches the select
    always_comb begin
        data = '0;
        for (int i = 0; i < NCH; i++) begin
            if (sel == SELW'(i)) begin
                data = cnt_bus[i*CW +: CW];
            end
        end
    end
endmodule

// File: rtl/evc_counter_bank.sv
// Bank of gated event down-counters with a shared timer enable,
// a preset-all strobe and a selectable read port.
// Assumes: gate_en and preset_wr are synchronous to clk; evt_in is not.
module evc_counter_bank
    import evc_pkg::*;
#(
    parameter int NCH  = EVC_NCH,
    parameter int CW   = EVC_CW,
    parameter int SELW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCH-1:0]  evt_in,
    input  logic            gate_en,
    input  logic            preset_wr,
    input  logic [SELW-1:0] rd_sel,
    output logic [CW-1:0]   rd_data,
    output logic [NCH-1:0]  ovf_flags
);
    logic [NCH-1:0]    evt_rise;
    logic [NCH-1:0]    evt_step;
    logic [NCH*CW-1:0] cnt_bus;

    evc_edge_sync #(.W(NCH)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (evt_in),
        .rise  (evt_rise)
    );

    // the shared gate qualifies every channel's edge in the same cycle
    assign evt_step = evt_rise & {NCH{gate_en}};

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        evc_chan_counter #(.CW(CW)) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .preset (preset_wr),
            .step   (evt_step[g]),
            .count  (cnt_bus[g*CW +: CW]),
            .ovf    (ovf_flags[g])
        );
    end

    evc_read_mux #(.NCH(NCH), .CW(CW), .SELW(SELW)) u_mux (
        .cnt_bus (cnt_bus),
        .sel     (rd_sel),
        .data    (rd_data)
    );
endmodule

// File: rtl/evc_checker.sv
// Property checker for the counter bank, attached by bind.
// Assumes: it sees the bank's internal counter bus.
module evc_checker #(
    parameter int NCH  = 10,
    parameter int CW   = 16,
    parameter int SELW = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              gate_en,
    input logic              preset_wr,
    input logic [SELW-1:0]   rd_sel,
    input logic [CW-1:0]     rd_data,
    input logic [NCH-1:0]    ovf_flags,
    input logic [NCH*CW-1:0] cnt_bus
);
    // R2
    preset_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        preset_wr |=> (cnt_bus == '1) && (ovf_flags == '0));

    // R4
    gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_en && !preset_wr) |=> $stable(cnt_bus));

    // R6
    sel_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel >= SELW'(NCH)) |-> (rd_data == '0));

    for (genvar g = 0; g < NCH; g++) begin : g_prop
        // R3
        single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(preset_wr) |-> ((cnt_bus[g*CW +: CW] == $past(cnt_bus[g*CW +: CW])) ||
                                   (cnt_bus[g*CW +: CW] == $past(cnt_bus[g*CW +: CW]) - 1'b1)));

        // R5
        ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(ovf_flags[g]) |-> $past(preset_wr));

        // R5
        ovf_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ovf_flags[g]) |-> (cnt_bus[g*CW +: CW] == '0));
    end
endmodule

bind evc_counter_bank evc_checker #(.NCH(NCH), .CW(CW), .SELW(SELW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .gate_en   (gate_en),
    .preset_wr (preset_wr),
    .rd_sel    (rd_sel),
    .rd_data   (rd_data),
    .ovf_flags (ovf_flags),
    .cnt_bus   (cnt_bus)
);

// File: tb/sim_evc_counter_bank.sv
// Self-checking bench for the gated event counter bank.
module sim_evc_counter_bank;
    localparam int NCH = 10;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] evt_in = '0;
    logic           gate_en = 1'b0;
    logic           preset_wr = 1'b0;
    logic [3:0]     rd_sel = '0;
    logic [15:0]    rd_data;
    logic [NCH-1:0] ovf_flags;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [15:0] exp_cnt [NCH];

    typedef struct packed {
        logic [9:0] mask;
        logic       gate;
        logic [7:0] npulse;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{mask: 10'h001, gate: 1'b1, npulse: 8'd3},
        '{mask: 10'h3FF, gate: 1'b1, npulse: 8'd2},
        '{mask: 10'h200, gate: 1'b0, npulse: 8'd5},
        '{mask: 10'h155, gate: 1'b1, npulse: 8'd4},
        '{mask: 10'h2AA, gate: 1'b1, npulse: 8'd1}
    };

    always #10 clk = ~clk;

    evc_counter_bank u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_in    (evt_in),
        .gate_en   (gate_en),
        .preset_wr (preset_wr),
        .rd_sel    (rd_sel),
        .rd_data   (rd_data),
        .ovf_flags (ovf_flags)
    );

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic read_chan(input int ch, input logic [15:0] exp, input string req);
        @(negedge clk);
        rd_sel = 4'(ch);
        #1;
        chk(rd_data, exp, req);
    endtask

    task automatic check_all(input string req);
        for (int c = 0; c < NCH; c++) read_chan(c, exp_cnt[c], req);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_preset();
        @(negedge clk);
        preset_wr = 1'b1;
        @(negedge clk);
        preset_wr = 1'b0;
        for (int c = 0; c < NCH; c++) exp_cnt[c] = 16'hFFFF;
    endtask

    // one pulse: high two cycles, low two cycles; the count lands inside the slot
    task automatic pulse(input logic [9:0] mask);
        @(negedge clk);
        evt_in = mask;
        idle(2);
        evt_in = '0;
        idle(1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < NCH; c++) exp_cnt[c] = 16'hFFFF;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        check_all("R1");
        chk(16'(ovf_flags), 16'h0, "R1 ovf");

        // R6 out-of-range selects read zero
        for (int s = 10; s < 16; s++) read_chan(s, 16'h0, "R6");

        // vector table: R3 R4 R8
        for (int v = 0; v < 5; v++) begin
            @(negedge clk);
            gate_en = VECS[v].gate;
            for (int p = 0; p < int'(VECS[v].npulse); p++) pulse(VECS[v].mask);
            for (int c = 0; c < NCH; c++)
                if (VECS[v].mask[c] && VECS[v].gate) exp_cnt[c] = exp_cnt[c] - 16'(VECS[v].npulse);
            idle(3);
            check_all(VECS[v].gate ? "R3/R8 table" : "R4 table");
        end

        // R2 preset reloads everything
        do_preset();
        check_all("R2");

        // R3 a long pulse counts once
        gate_en = 1'b1;
        @(negedge clk);
        evt_in = 10'h001;
        idle(20);
        evt_in = '0;
        idle(4);
        exp_cnt[0] = 16'hFFFE;
        read_chan(0, exp_cnt[0], "R3 long pulse");

        // R7 latency on channel 1: unchanged after edges 1 and 2, changed after 3
        @(negedge clk);
        rd_sel = 4'd1;
        evt_in = 10'h002;
        @(negedge clk); #1 chk(rd_data, 16'hFFFF, "R7 edge1");
        @(negedge clk); #1 chk(rd_data, 16'hFFFF, "R7 edge2");
        evt_in = '0;
        @(negedge clk); #1 chk(rd_data, 16'hFFFE, "R7 edge3");
        exp_cnt[1] = 16'hFFFE;
        idle(2);

        // R4 gate falls exactly on the counting edge: not counted
        @(negedge clk);
        evt_in = 10'h004;
        idle(2);
        gate_en = 1'b0;
        evt_in = '0;
        idle(4);
        read_chan(2, 16'hFFFF, "R4 gate fall");
        gate_en = 1'b1;
        idle(4);
        read_chan(2, 16'hFFFF, "R4 lost edge");

        // R2 preset wins over an edge landing on the same clock edge
        @(negedge clk);
        evt_in = 10'h008;
        idle(2);
        preset_wr = 1'b1;
        evt_in = '0;
        @(negedge clk);
        preset_wr = 1'b0;
        idle(3);
        for (int c = 0; c < NCH; c++) exp_cnt[c] = 16'hFFFF;
        check_all("R2 priority");

        // R5 saturation on channel 9
        for (int k = 0; k < 65535; k++) begin
            @(negedge clk);
            evt_in = 10'h200;
            @(negedge clk);
            evt_in = '0;
        end
        idle(4);
        read_chan(9, 16'h0000, "R5 reach zero");
        chk(16'(ovf_flags), 16'h0, "R5 no flag at zero");
        pulse(10'h200);
        idle(3);
        read_chan(9, 16'h0000, "R5 hold zero");
        chk(16'(ovf_flags), 16'h0200, "R5 flag set");
        gate_en = 1'b0;
        idle(10);
        chk(16'(ovf_flags), 16'h0200, "R5 flag sticky");
        do_preset();
        chk(16'(ovf_flags), 16'h0, "R5 flag cleared");
        read_chan(9, 16'hFFFF, "R5 reload");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule